// File: doc/BRIEF.md
# Shared-counter PWM timer

This block generates several edge-aligned PWM waveforms from a single up-counter that all channels share. Software reaches it through a plain word-wide register port: a write strobe with address and data, and a read-data output that follows the address combinationally. A configuration register holds a clock divider exponent and a run-mode code. A period register sets the count at which the shared counter wraps. Each channel has a control register and a compare register.

While the counter is stopped, period and compare writes land at once. While it runs, they wait in shadow registers and all of them move into the active set together at the next wrap. This keeps every period self-consistent. Each channel output is high from the wrap until the count reaches its compare value. The output can be inverted, or it can be held low. A per-channel flag records a compare match and is cleared by writing one to it.

Top module: `pwm_timer`

## Requirements
- R1: After reset, every register reads 0 except the channel-count register, the counter is stopped, and all `pwm_o` bits are 0.
- R2: Address 0x04 reads the number of channels in bits [7:0], and writes to it have no effect.
- R3: With run code 01 in configuration bits [4:3] (register 0x10), the counter steps 0,1,...,P and then returns to 0, where P is the active period, giving P+1 steps per period.
- R4: Run codes 00, 10 and 11 stop the counter, and its value holds.
- R5: Configuration bits [2:0] hold an exponent E, and a running counter advances once every 2^E clock cycles.
- R6: Address 0x14 reads the counter, and a write of any value there clears the counter to 0.
- R7: While stopped, writes to the period register (0x18, bits [15:0]) or to a channel compare register (0x24+8n, bits [15:0]) take effect at once, and a read returns the new value.
- R8: While running, those writes are held back, reads still return the old active values, and all pending values become active together when the counter next wraps.
- R9: Channel control (0x20+8n) bit 5 set with bits [3:2]=10 drives the output high while count < compare. With bits [3:2]=01 the output is the inverse of that. Bits [3:2]=00 or 11, or bit 5 clear, hold the output at 0. A compare of 0 gives a constant low and a compare above the period gives a constant high.
- R10: A change of channel control bits [3:2] or bit 5 affects the output in the next cycle, without waiting for a wrap.
- R11: Channel control bit 7 is set when the counter advances from a value equal to that channel's active compare. Writing 1 to bit 7 clears it, writing 0 leaves it alone, and a new match wins over a clear.
- R12: Configuration bit 5 always reads 0, whatever is written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (8) | Register byte address |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for `addr_i` |
| pwm_o | output | NCH (4) | Channel PWM outputs |

## Verification
A reference model in the bench follows the counter, the divider, the shadow registers, the flags and every output, and the bench compares each PWM bit against it on every clock.

The channels are set up so that one run exercises every output rule at once: a mid-range compare, a compare of 0, a compare above the period, and an inverted channel. This separates the level rule from the edge cases.

The period is rewritten while the counter runs and again while it is stopped. This separates buffered loading from immediate loading. Divider exponents 0, 2 and 7 check the step rate. The two reserved run codes check that the counter holds. Output-select changes made mid-period show that they act without waiting for a wrap.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int PS_W = 3;
  localparam logic [7:0] OFF_INFO    = 8'h04;
  localparam logic [7:0] OFF_CFG     = 8'h10;
  localparam logic [7:0] OFF_COUNT   = 8'h14;
  localparam logic [7:0] OFF_PERIOD  = 8'h18;
  localparam int         OFF_CH_BASE = 32'h20;
  localparam int         CH_STRIDE   = 8;
  localparam int         CH_CMP_OFS  = 4;

  typedef enum logic [1:0] {
    RUN_OFF   = 2'b00,
    RUN_CLK   = 2'b01,
    RUN_RSV_A = 2'b10,
    RUN_RSV_B = 2'b11
  } run_mode_e;

  typedef enum logic [1:0] {
    OUT_LOW_A = 2'b00,
    OUT_INV   = 2'b01,
    OUT_NORM  = 2'b10,
    OUT_LOW_B = 2'b11
  } out_sel_e;

  typedef struct packed {
    logic     edge_mode;
    logic     aux_mode;
    out_sel_e out_sel;
  } ch_ctl_t;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale
  import pwm_timer_pkg::*;
#(
  parameter int EXP_W = PS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam int DIV_W = (1 << EXP_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask = ~({DIV_W{1'b1}} << exp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               div_q <= '0;
    else if (!run_i || clr_i)  div_q <= '0;
    else                       div_q <= div_q + 1'b1;
  end

  assign tick_o = run_i && ((div_q & mask) == mask);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             mod_wr_i,
  input  logic [CNT_W-1:0] mod_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] mod_act_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, mod_act_q, mod_buf_q;

  // >= also recovers when the period was lowered below the count while stopped
  assign wrap_o = tick_i && (cnt_q >= mod_act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      mod_act_q <= '0;
      mod_buf_q <= '0;
    end else begin
      if (clr_i)       cnt_q <= '0;
      else if (tick_i) cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;

      if (mod_wr_i) mod_buf_q <= mod_wdata_i;

      if (mod_wr_i && !run_i) mod_act_q <= mod_wdata_i;
      else if (wrap_o)        mod_act_q <= mod_buf_q;
    end
  end

  assign cnt_o     = cnt_q;
  assign mod_act_o = mod_act_q;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             ctl_wr_i,
  input  ch_ctl_t          ctl_wdata_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cmp_act_o,
  output ch_ctl_t          ctl_o,
  output logic             flag_o,
  output logic             out_en_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cmp_act_q, cmp_buf_q;
  ch_ctl_t          ctl_q;
  logic             flag_q;
  logic             level;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_act_q <= '0;
      cmp_buf_q <= '0;
      ctl_q     <= '0;
      flag_q    <= 1'b0;
    end else begin
      if (cmp_wr_i) cmp_buf_q <= cmp_wdata_i;

      if (cmp_wr_i && !run_i) cmp_act_q <= cmp_wdata_i;
      else if (wrap_i)        cmp_act_q <= cmp_buf_q;

      if (ctl_wr_i) ctl_q <= ctl_wdata_i;

      // a fresh match beats a software clear
      if (tick_i && (cnt_i == cmp_act_q)) flag_q <= 1'b1;
      else if (flag_clr_i)                flag_q <= 1'b0;
    end
  end

  assign level    = cnt_i < cmp_act_q;
  assign out_en_o = ctl_q.edge_mode &&
                    ((ctl_q.out_sel == OUT_NORM) || (ctl_q.out_sel == OUT_INV));
  assign pwm_o    = out_en_o && (level ^ (ctl_q.out_sel == OUT_INV));

  assign cmp_act_o = cmp_act_q;
  assign ctl_o     = ctl_q;
  assign flag_o    = flag_q;
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NCH-1:0]    pwm_o
);
  logic [PS_W-1:0]  ps_q;
  run_mode_e        cmod_q;
  logic             run, tick, wrap;
  logic             cfg_wr, cnt_clr, mod_wr;
  logic [CNT_W-1:0] cnt, mod_act;
  logic [CNT_W-1:0] cmp_act [NCH];
  ch_ctl_t          ctl     [NCH];
  logic [NCH-1:0]   flag, out_en;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:CNT_W];

  assign cfg_wr  = we_i && (addr_i == ADDR_W'(OFF_CFG));
  assign cnt_clr = we_i && (addr_i == ADDR_W'(OFF_COUNT));
  assign mod_wr  = we_i && (addr_i == ADDR_W'(OFF_PERIOD));
  assign run     = (cmod_q == RUN_CLK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q   <= '0;
      cmod_q <= RUN_OFF;
    end else if (cfg_wr) begin
      ps_q   <= wdata_i[PS_W-1:0];
      cmod_q <= run_mode_e'(wdata_i[4:3]);
    end
  end

  pwm_prescale #(.EXP_W(PS_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .clr_i  (cnt_clr),
    .exp_i  (ps_q),
    .tick_o (tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .tick_i      (tick),
    .clr_i       (cnt_clr),
    .mod_wr_i    (mod_wr),
    .mod_wdata_i (wdata_i[CNT_W-1:0]),
    .cnt_o       (cnt),
    .mod_act_o   (mod_act),
    .wrap_o      (wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic ctl_hit, cmp_hit;
    assign ctl_hit = we_i && (addr_i == ADDR_W'(OFF_CH_BASE + g * CH_STRIDE));
    assign cmp_hit = we_i && (addr_i == ADDR_W'(OFF_CH_BASE + g * CH_STRIDE + CH_CMP_OFS));

    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (run),
      .tick_i      (tick),
      .wrap_i      (wrap),
      .cnt_i       (cnt),
      .cmp_wr_i    (cmp_hit),
      .cmp_wdata_i (wdata_i[CNT_W-1:0]),
      .ctl_wr_i    (ctl_hit),
      .ctl_wdata_i (ch_ctl_t'(wdata_i[5:2])),
      .flag_clr_i  (ctl_hit && wdata_i[7]),
      .cmp_act_o   (cmp_act[g]),
      .ctl_o       (ctl[g]),
      .flag_o      (flag[g]),
      .out_en_o    (out_en[g]),
      .pwm_o       (pwm_o[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_INFO))   rdata_o[7:0]       = 8'(NCH);
    if (addr_i == ADDR_W'(OFF_CFG))    rdata_o[4:0]       = {cmod_q, ps_q};
    if (addr_i == ADDR_W'(OFF_COUNT))  rdata_o[CNT_W-1:0] = cnt;
    if (addr_i == ADDR_W'(OFF_PERIOD)) rdata_o[CNT_W-1:0] = mod_act;
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == ADDR_W'(OFF_CH_BASE + i * CH_STRIDE))
        rdata_o[7:0] = {flag[i], 1'b0, ctl[i], 2'b00};
      if (addr_i == ADDR_W'(OFF_CH_BASE + i * CH_STRIDE + CH_CMP_OFS))
        rdata_o[CNT_W-1:0] = cmp_act[i];
    end
  end
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
  import pwm_timer_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run,
  input logic              tick,
  input logic              wrap,
  input logic              cnt_clr,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  mod_act,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o
);
  a_r3_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !cnt_clr && (cnt < mod_act)) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  a_r3_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !cnt_clr) |=> (cnt == '0));

  a_r4_hold_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !cnt_clr) |=> $stable(cnt));

  a_r6_count_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr |=> (cnt == '0));

  a_r8_period_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !wrap) |=> $stable(mod_act));

  a_r2_info_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFF_INFO)) |-> (rdata_o == DATA_W'(NCH)));

  a_r12_no_center: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFF_CFG)) |-> (rdata_o[DATA_W-1:5] == '0));
endmodule

bind pwm_timer pwm_timer_chk #(
  .NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run     (run),
  .tick    (tick),
  .wrap    (wrap),
  .cnt_clr (cnt_clr),
  .cnt     (cnt),
  .mod_act (mod_act),
  .addr_i  (addr_i),
  .rdata_o (rdata_o)
);

// File: tb/pwm_timer_tb.sv
module pwm_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        we_i;
  logic [7:0]  addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic [NCH-1:0] pwm_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_ps, m_cmod, m_pcnt, m_cnt, m_mod_act, m_mod_buf;
  int m_cmp_act [NCH];
  int m_cmp_buf [NCH];
  int m_ctl     [NCH];
  int m_flag    [NCH];
  int t_mask;
  bit t_run, t_tick, t_wrap;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwm_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pwm_o(pwm_o)
  );

  function automatic int ctl_a(int n); return 32'h20 + 8 * n; endfunction
  function automatic int cmp_a(int n); return 32'h24 + 8 * n; endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ps = 0; m_cmod = 0; m_pcnt = 0; m_cnt = 0; m_mod_act = 0; m_mod_buf = 0;
      for (int c = 0; c < NCH; c++) begin
        m_cmp_act[c] = 0; m_cmp_buf[c] = 0; m_ctl[c] = 0; m_flag[c] = 0;
      end
    end else begin
      t_run  = (m_cmod == 1);
      t_mask = (1 << m_ps) - 1;
      t_tick = t_run && ((m_pcnt & t_mask) == t_mask);
      t_wrap = t_tick && (m_cnt >= m_mod_act);
      for (int c = 0; c < NCH; c++) begin
        if (t_tick && m_cnt == m_cmp_act[c]) m_flag[c] = 1;
        else if (we_i && addr_i == 8'(ctl_a(c)) && wdata_i[7]) m_flag[c] = 0;
        if (we_i && addr_i == 8'(ctl_a(c))) m_ctl[c] = int'(wdata_i[5:2]);
        if (we_i && addr_i == 8'(cmp_a(c)) && !t_run) m_cmp_act[c] = int'(wdata_i[15:0]);
        else if (t_wrap) m_cmp_act[c] = m_cmp_buf[c];
        if (we_i && addr_i == 8'(cmp_a(c))) m_cmp_buf[c] = int'(wdata_i[15:0]);
      end
      if (we_i && addr_i == 8'h18 && !t_run) m_mod_act = int'(wdata_i[15:0]);
      else if (t_wrap) m_mod_act = m_mod_buf;
      if (we_i && addr_i == 8'h18) m_mod_buf = int'(wdata_i[15:0]);
      if ((we_i && addr_i == 8'h14) || !t_run) m_pcnt = 0;
      else m_pcnt = (m_pcnt + 1) & 127;
      if (we_i && addr_i == 8'h14) m_cnt = 0;
      else if (t_tick) m_cnt = t_wrap ? 0 : m_cnt + 1;
      if (we_i && addr_i == 8'h10) begin
        m_ps = int'(wdata_i[2:0]); m_cmod = int'(wdata_i[4:3]);
      end
    end
  end

  function automatic logic m_out(int c);
    int  els = m_ctl[c] & 3;
    bit  en  = ((m_ctl[c] >> 3) & 1) == 1 && (els == 1 || els == 2);
    bit  lvl = m_cnt < m_cmp_act[c];
    return en ? ((els == 1) ? !lvl : lvl) : 1'b0;
  endfunction

  function automatic logic [31:0] m_read(int a);
    if (a == 'h04) return 32'(NCH);
    if (a == 'h10) return 32'((m_cmod << 3) | m_ps);
    if (a == 'h14) return 32'(m_cnt);
    if (a == 'h18) return 32'(m_mod_act);
    for (int c = 0; c < NCH; c++) begin
      if (a == ctl_a(c)) return 32'((m_flag[c] << 7) | (m_ctl[c] << 2));
      if (a == cmp_a(c)) return 32'(m_cmp_act[c]);
    end
    return 32'h0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // R9 R10: every output compared with the model each cycle
  always @(negedge clk_i) begin
    if (rst_ni === 1'b1) begin
      for (int c = 0; c < NCH; c++) chk("R9 output", 32'(pwm_o[c]), 32'(m_out(c)));
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = 8'(a); wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(int a, string req);
    @(negedge clk_i);
    addr_i = 8'(a);
    #1;
    chk(req, rdata_o, m_read(a));
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0; we_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 reset state
    chk("R1 outputs", 32'(pwm_o), 32'h0);
    rd('h10, "R1 cfg"); chk("R1 cfg", rdata_o, 32'h0);
    rd('h14, "R1 count");
    rd('h18, "R1 period");
    rd(ctl_a(0), "R1 ctl0");
    rd(cmp_a(3), "R1 cmp3");

    // R2 channel count, read-only
    rd('h04, "R2 info"); chk("R2 info", rdata_o, 32'd4);
    wr('h04, 32'hFF);
    rd('h04, "R2 info after write"); chk("R2 info after write", rdata_o, 32'd4);

    // R7 immediate while stopped
    wr('h18, 9);
    rd('h18, "R7 period"); chk("R7 period", rdata_o, 32'd9);
    wr(cmp_a(0), 3); wr(cmp_a(1), 0); wr(cmp_a(2), 20); wr(cmp_a(3), 5);
    rd(cmp_a(0), "R7 cmp0"); chk("R7 cmp0", rdata_o, 32'd3);
    wr(ctl_a(0), 'h28); wr(ctl_a(1), 'h28); wr(ctl_a(2), 'h28); wr(ctl_a(3), 'h24);

    // R3 counting and wrap
    wr('h10, 'h08);
    for (int i = 0; i < 30; i++) rd('h14, "R3 count");

    // R11 flag set and write-0 no effect
    rd(ctl_a(0), "R11 flag set");
    wr(ctl_a(0), 'h28);
    rd(ctl_a(0), "R11 write zero keeps flag");

    // R8 buffered while running
    wr('h14, 0);
    wr('h18, 4);
    wr(cmp_a(0), 2);
    rd('h18, "R8 period held"); chk("R8 period held", rdata_o, 32'd9);
    rd(cmp_a(0), "R8 cmp held"); chk("R8 cmp held", rdata_o, 32'd3);
    repeat (12) @(negedge clk_i);
    rd('h18, "R8 period loaded"); chk("R8 period loaded", rdata_o, 32'd4);
    rd(cmp_a(0), "R8 cmp loaded"); chk("R8 cmp loaded", rdata_o, 32'd2);
    for (int i = 0; i < 12; i++) rd('h14, "R3 count new period");

    // R10 output select takes effect at once
    wr(ctl_a(0), 'h24);
    rd(ctl_a(0), "R10 ctl0 inverted");
    repeat (5) @(negedge clk_i);
    wr(ctl_a(0), 'h08);
    chk("R10 disabled output low", 32'(pwm_o[0]), 32'h0);
    repeat (5) @(negedge clk_i);
    wr(ctl_a(0), 'h28);

    // R5 prescaler exponent 2
    wr('h10, 'h0A);
    wr('h14, 0);
    for (int i = 0; i < 16; i++) rd('h14, "R5 divided count");

    // R4 stop codes
    wr('h10, 'h10);
    rd('h14, "R4 stopped 10");
    repeat (6) @(negedge clk_i);
    rd('h14, "R4 stopped 10 later");
    wr('h10, 'h18);
    repeat (6) @(negedge clk_i);
    rd('h14, "R4 stopped 11");

    // R7 again, R6 clear
    wr('h18, 7);
    rd('h18, "R7 period stopped"); chk("R7 period stopped", rdata_o, 32'd7);
    wr('h14, 'h1234);
    rd('h14, "R6 count cleared"); chk("R6 count cleared", rdata_o, 32'd0);

    // R11 write 1 clears
    wr(ctl_a(0), 'hA8);
    rd(ctl_a(0), "R11 cleared"); chk("R11 cleared", 32'(rdata_o[7]), 32'h0);

    // R12 center bit ignored, then slow run with exponent 7
    wr('h10, 'h2F);
    rd('h10, "R12 cfg"); chk("R12 cfg", rdata_o, 32'h0F);
    repeat (400) @(negedge clk_i);
    rd('h14, "R5 exponent 7");

    summary();
    $finish;
  end
endmodule